// File: doc/BRIEF.md
# Saturating Extrinsic Subtractor

This block follows one soft-output decoder stage inside an iterative turbo decoder. Each cycle it may accept a pair of signed 8-bit values: the stage's soft output and the extrinsic value that the other stage fed into it. Before it uses the incoming extrinsic value, the block limits that value to a symmetric window. It then subtracts the limited value from the soft output in a width that cannot overflow, limits the difference to the same window, and registers the result as the new extrinsic value for the next stage.

The window is `-2^k .. 2^k-1`, and k comes from a small configuration register. The window is narrower than the 8-bit storage on purpose. Soft outputs clip at +127, so if a strong channel sample is combined with a large extrinsic value, the information can cancel to zero after the subtraction. Keeping extrinsic values well inside the storage range avoids that loss. The usual setting is ±64, and ±32 and ±128 are also available.

Top module: `ext_limit_sub`

## Requirements
- R1: While `rstN` is low, `outValid` and `outExt` are 0 and the limit code resets to 1 (k = 6, window -64..+63).
- R2: `outValid` equals `inValid` from exactly one clock earlier, and each accepted pair produces its result at that same edge.
- R3: The incoming extrinsic value is clamped to the window `-2^k .. 2^k-1` before the subtraction.
- R4: The difference `softIn - clampedExt` is formed in 9 bits with no wraparound. A positive soft value minus a negative extrinsic value never yields a negative result. A negative soft value minus a positive extrinsic value never yields a non-negative result.
- R5: `outExt` is the difference clamped to the same window, so it always lies in `-2^k .. 2^k-1` for the k in force when the pair was accepted.
- R6: Limit code encoding on `cfgCode`: 0 gives k = 5 (±32), 1 gives k = 6 (±64), 2 gives k = 7 (full 8-bit range), and 3 also gives k = 7.
- R7: A write (`cfgWr` high) takes effect for pairs accepted from the next cycle onward. A pair accepted in the same cycle as the write uses the previous limit.
- R8: While `inValid` is low, `outExt` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An input pair is present this cycle |
| softIn | input | 8 | Signed soft output of the decoder stage |
| extIn | input | 8 | Signed extrinsic value that was fed into that stage |
| cfgWr | input | 1 | Write strobe for the limit code |
| cfgCode | input | 2 | Limit code (see R6) |
| outValid | output | 1 | New extrinsic value valid |
| outExt | output | 8 | Signed clamped new extrinsic value |

## Verification
Every result is due on the first rising edge after the cycle in which its pair was presented. That edge also decides `outValid`. A configuration write changes only the pairs that follow it, one cycle later. The driver puts one scoreboard entry on the queue for every cycle it drives, whether or not that cycle carries a valid pair. The monitor takes one entry off the queue one time unit after each rising edge. Because of this, a result that arrives a cycle early or late shows up as a valid or data mismatch. The bench keeps its own copy of the limit and updates it only after the write cycle, so the same-cycle case is predicted independently of the design.

// File: rtl/ext_limit_pkg.sv
package ext_limit_pkg;
  localparam int K_W = 5;

  typedef struct packed {
    logic           capture;
    logic [K_W-1:0] limK;
  } ctrlStrobes_t;
endpackage

// File: rtl/ext_limit_clamp.sv
module ext_limit_clamp #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0]                 din,
  input  logic [ext_limit_pkg::K_W-1:0]          limK,
  output logic signed [OUT_W-1:0]                dout
);
  localparam int EW = IN_W + 1;

  logic [EW-1:0]        span;
  logic signed [EW-1:0] hiV;
  logic signed [EW-1:0] loV;
  logic signed [EW-1:0] dinX;

  always_comb begin
    span = EW'(1) << limK;
    hiV  = signed'(span - EW'(1));
    loV  = -signed'(span);
    dinX = {din[IN_W-1], din};
    if (dinX > hiV)      dout = hiV[OUT_W-1:0];
    else if (dinX < loV) dout = loV[OUT_W-1:0];
    else                 dout = dinX[OUT_W-1:0];
  end
endmodule

// File: rtl/ext_limit_ctrl.sv
module ext_limit_ctrl
  import ext_limit_pkg::*;
#(
  parameter int CODE_W     = 2,
  parameter int K_MIN      = 5,
  parameter int K_MAX      = 7,
  parameter int RESET_CODE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              cfgWr,
  input  logic [CODE_W-1:0] cfgCode,
  output ctrlStrobes_t      strb,
  output logic              outValid
);
  logic [CODE_W-1:0] codeReg;
  logic [K_W-1:0]    kSum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg  <= CODE_W'(RESET_CODE);
      outValid <= 1'b0;
    end else begin
      if (cfgWr) codeReg <= cfgCode;
      outValid <= inValid;
    end
  end

  always_comb begin
    kSum         = K_W'(K_MIN) + K_W'(codeReg);
    strb.capture = inValid;
    strb.limK    = (kSum > K_W'(K_MAX)) ? K_W'(K_MAX) : kSum;
  end
endmodule

// File: rtl/ext_limit_dp.sv
module ext_limit_dp
  import ext_limit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strb,
  input  logic signed [DATA_W-1:0] softIn,
  input  logic signed [DATA_W-1:0] extIn,
  output logic signed [DATA_W-1:0] extLim,
  output logic signed [DATA_W-1:0] outExt
);
  localparam int DIFF_W = DATA_W + 1;

  logic signed [DIFF_W-1:0] diff;
  logic signed [DATA_W-1:0] diffLim;

  ext_limit_clamp #(.IN_W(DATA_W), .OUT_W(DATA_W)) u_extClamp (
    .din (extIn),
    .limK(strb.limK),
    .dout(extLim)
  );

  assign diff = {softIn[DATA_W-1], softIn} - {extLim[DATA_W-1], extLim};

  ext_limit_clamp #(.IN_W(DIFF_W), .OUT_W(DATA_W)) u_diffClamp (
    .din (diff),
    .limK(strb.limK),
    .dout(diffLim)
  );

  always_ff @(posedge clk) begin
    if (!rstN)             outExt <= '0;
    else if (strb.capture) outExt <= diffLim;
  end
endmodule

// File: rtl/ext_limit_sub.sv
module ext_limit_sub
  import ext_limit_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CODE_W     = 2,
  parameter int K_MIN      = 5,
  parameter int RESET_CODE = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] softIn,
  input  logic signed [DATA_W-1:0] extIn,
  input  logic                     cfgWr,
  input  logic [CODE_W-1:0]        cfgCode,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outExt
);
  localparam int K_MAX = DATA_W - 1;

  ctrlStrobes_t             strb;
  logic [K_W-1:0]           curK;
  logic signed [DATA_W-1:0] extLim;

  ext_limit_ctrl #(
    .CODE_W(CODE_W), .K_MIN(K_MIN), .K_MAX(K_MAX), .RESET_CODE(RESET_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cfgWr(cfgWr),
    .cfgCode(cfgCode), .strb(strb), .outValid(outValid)
  );

  ext_limit_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .softIn(softIn), .extIn(extIn),
    .extLim(extLim), .outExt(outExt)
  );

  assign curK = strb.limK;
endmodule

// File: rtl/ext_limit_sub_chk.sv
module ext_limit_sub_chk #(
  parameter int DATA_W = 8,
  parameter int K_MIN  = 5
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          inValid,
  input logic signed [DATA_W-1:0]      softIn,
  input logic signed [DATA_W-1:0]      extIn,
  input logic                          outValid,
  input logic signed [DATA_W-1:0]      outExt,
  input logic [ext_limit_pkg::K_W-1:0] curK,
  input logic signed [DATA_W-1:0]      extLim
);
  function automatic bit inWin(logic signed [DATA_W-1:0] v, logic [ext_limit_pkg::K_W-1:0] k);
    int hi;
    hi = (1 << k) - 1;
    return (int'(v) <= hi) && (int'(v) >= -(hi + 1));
  endfunction

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_idle_delay: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r3_ext_window: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> inWin(extLim, curK));
  a_r4_pos_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !softIn[DATA_W-1] && extIn[DATA_W-1]) |=> !outExt[DATA_W-1]);
  a_r4_neg_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && softIn[DATA_W-1] && !extIn[DATA_W-1] && extIn != '0) |=> outExt[DATA_W-1]);
  a_r5_out_window: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> inWin(outExt, $past(curK)));
  a_r6_k_legal: assert property (@(posedge clk) disable iff (!rstN)
    (int'(curK) >= K_MIN) && (int'(curK) <= DATA_W - 1));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outExt));
endmodule

bind ext_limit_sub ext_limit_sub_chk #(.DATA_W(DATA_W), .K_MIN(K_MIN)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .softIn(softIn), .extIn(extIn),
  .outValid(outValid), .outExt(outExt), .curK(curK), .extLim(extLim)
);

// File: tb/ext_limit_sub_bench.sv
`timescale 1ns/1ps
module ext_limit_sub_bench;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic signed [7:0] softIn = '0;
  logic signed [7:0] extIn = '0;
  logic              cfgWr = 1'b0;
  logic [1:0]        cfgCode = '0;
  logic              outValid;
  logic signed [7:0] outExt;

  typedef struct {
    bit    v;
    int    exp;
    string tag;
  } sbItem_t;

  sbItem_t q[$];
  int compared = 0;
  int mismatched = 0;
  int benchK = 6;
  int lastExp = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_limit_sub u_ext_limit_sub (
    .clk(clk), .rstN(rstN), .inValid(inValid), .softIn(softIn), .extIn(extIn),
    .cfgWr(cfgWr), .cfgCode(cfgCode), .outValid(outValid), .outExt(outExt)
  );

  function automatic int clampK(int v, int k);
    int hi = (1 << k) - 1;
    if (v > hi) return hi;
    if (v < -(hi + 1)) return -(hi + 1);
    return v;
  endfunction

  function automatic int kOf(int code);
    return (code == 0) ? 5 : (code == 1) ? 6 : 7;
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int s, int e, bit wr, int code, string tag);
    sbItem_t it;
    @(negedge clk);
    inValid = v; softIn = 8'(s); extIn = 8'(e); cfgWr = wr; cfgCode = 2'(code);
    it.v = v;
    it.exp = v ? clampK(s - clampK(e, benchK), benchK) : 0;
    it.tag = tag;
    q.push_back(it);
    if (v) lastExp = it.exp;
    if (wr) benchK = kOf(code);
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && q.size() > 0) begin
      sbItem_t it;
      it = q.pop_front();
      if (outValid !== it.v) check({it.tag, "/R2 valid"}, int'(outValid), int'(it.v));
      else if (it.v) check(it.tag, int'(outExt), it.exp);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", int'(outValid), 0);
    check("R1 outExt in reset", int'(outExt), 0);
    @(negedge clk);
    rstN = 1'b1;
    // R1 default limit +-64: 127 - clamp(127)=64 -> 63
    step(1, 127, 127, 0, 0, "R1 default window");
    step(1, -128, -128, 0, 0, "R1 default window");
    // R4: wide difference must not wrap
    step(1, 127, -128, 0, 0, "R4 pos minus neg");
    step(1, -128, 127, 0, 0, "R4 neg minus pos");
    // R5 full sweep at k=6
    for (int s = -128; s < 128; s++)
      for (int e = -128; e < 128; e++)
        step(1, s, e, 0, 0, "R5 sweep k6");
    // R8 hold while idle
    step(0, 5, 5, 0, 0, "R8 idle");
    step(0, -9, 3, 0, 0, "R8 idle");
    step(0, 0, 0, 0, 0, "R8 idle");
    @(negedge clk);
    check("R8 hold", int'(outExt), lastExp);
    // R7 write same cycle uses old limit, next uses new (code 0 -> k5)
    step(1, 100, 0, 1, 0, "R7 same-cycle old limit");
    step(1, 100, 0, 0, 0, "R7 next-cycle new limit");
    // R3/R6 k=5 sweep
    for (int s = -128; s < 128; s++)
      for (int e = -128; e < 128; e += 4)
        step(1, s, e, 0, 0, "R3 sweep k5");
    // R6 code 2 -> k7
    step(0, 0, 0, 1, 2, "R6 cfg write");
    for (int s = -128; s < 128; s++)
      for (int e = -127; e < 128; e += 4)
        step(1, s, e, 0, 0, "R6 sweep k7");
    // R6 code 3 behaves as k7
    step(0, 0, 0, 1, 3, "R6 cfg write");
    step(1, 127, -128, 0, 0, "R6 code3 full range");
    step(1, -128, 127, 0, 0, "R6 code3 full range");
    step(1, 40, -100, 0, 0, "R6 code3 full range");
    step(0, 0, 0, 0, 0, "R2 tail");
    step(0, 0, 0, 0, 0, "R2 tail");
    @(negedge clk);
    @(negedge clk);
    check("R2 queue drained", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule